// File: doc/BRIEF.md
# Highest Priority Pending Selector

This block picks, for one processor, the single interrupt that should be signalled next. Each interrupt ID comes with an eligibility bit, an 8-bit priority, a group bit and a group-modifier bit. The block walks over the IDs one per clock cycle and keeps a running best. IDs 0 to 31 are private to the processor. Shared IDs follow from 32 upward, and each has a routing-valid bit that says whether it targets an implemented processor. A message-interrupt candidate can also be folded in, but only while its enable conditions hold.

The owner can request one of three kinds of sweep. A full sweep discards the recorded best, then visits all shared IDs, then the private IDs, and then the message candidate. A shared-range sweep visits only a window of shared IDs and merges them into the recorded best. A local sweep visits the private IDs and the message candidate and merges them the same way. If an incremental sweep finds nothing at least as good as the recorded best, and that best lies inside the swept region, the old winner may have lost urgency. In that case the block starts a full sweep by itself. A one-cycle done pulse marks the end of the whole operation, and the published winner changes only with that pulse.

Top module: `prio_pick`

## Requirements
- R1: A numerically lower priority is more urgent. A candidate with priority 0xFF is never selected. `valid_o` is low and `best_prio_o` reads 0xFF when nothing is recorded. Priority of ID i sits in `prio_i[8*i+7:8*i]`.
- R2: When priorities are equal, the lower ID wins.
- R3: A shared ID whose `route_ok_i` bit (bit i-32 for ID i) is low is never selected, however urgent it is.
- R4: A shared-range sweep (kind 1) visits IDs `upd_first_i` through `upd_first_i+upd_count_i-1`, clipped to the shared region. It replaces the recorded best only with a better candidate from that window. If the recorded best lies outside the window, no full sweep follows, and done arrives `upd_count_i+2` cycles after the accepting edge.
- R5: A candidate that equals the recorded best in both ID and priority counts as better. Sweeping a window that still holds an unchanged winner therefore does not start a full sweep.
- R6: After a shared-range or local sweep, a full sweep follows automatically when three things hold: no candidate was taken, the recorded best is valid, and the recorded best is inside the swept region. For a local sweep the region is the private IDs plus IDs at or above `MSG_BASE`.
- R7: The winner's group code is 2 when its group bit is 1. When its group bit is 0, the code is 1 if its modifier bit is 1 and `sec_dis_i` is low, and 0 otherwise.
- R8: The message candidate (ID `msg_id_i`, group `msg_grp_i`) is merged only by full and local sweeps (kind 2). It is merged only when `msg_lcl_en_i`, `msg_glb_en_i` and `g1ns_en_i` are all high and `msg_prio_i` is not 0xFF.
- R9: `done_o` is a one-cycle pulse. The outputs `valid_o`, `best_id_o`, `best_prio_o` and `best_grp_o` change only in the cycle `done_o` is high. `done_o` never coincides with `busy_o`.
- R10: A request is accepted only while idle and only with kind 0, 1 or 2. Requests made while busy, and requests with kind 3, are ignored.
- R11: A full sweep (kind 0) raises done `NUM_SHARED+35` cycles after the accepting edge. A local sweep that does not fall back raises done after 35 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Sweep request |
| req_kind_i | input | 2 | 0 full, 1 shared range, 2 local, 3 ignored |
| upd_first_i | input | 16 | First ID of a shared-range sweep |
| upd_count_i | input | 16 | Number of IDs in a shared-range sweep |
| elig_i | input | NUM_SHARED+32 | Eligibility bit per ID |
| route_ok_i | input | NUM_SHARED | Routing-valid bit per shared ID |
| prio_i | input | 8*(NUM_SHARED+32) | Priority per ID |
| grp_i | input | NUM_SHARED+32 | Group bit per ID |
| gmod_i | input | NUM_SHARED+32 | Group modifier bit per ID |
| sec_dis_i | input | 1 | Security disabled: modifier bits ignored |
| msg_lcl_en_i | input | 1 | Local message-interrupt enable |
| msg_glb_en_i | input | 1 | Global message-interrupt enable |
| g1ns_en_i | input | 1 | Non-secure group-1 enable |
| msg_id_i | input | 16 | Message candidate ID |
| msg_prio_i | input | 8 | Message candidate priority |
| msg_grp_i | input | 2 | Message candidate group code |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Sweep finished, outputs updated |
| valid_o | output | 1 | A winner is recorded |
| best_id_o | output | 16 | Winner ID |
| best_prio_o | output | 8 | Winner priority |
| best_grp_o | output | 2 | Winner group code |

## Verification
Full sweeps run with distinct priorities, with three-way ties that span the private and shared regions, with unrouted urgent IDs and with an all-0xFF set. Together these separate the priority order, the lowest-ID tie-break and the routing mask. Incremental sweeps are driven with a new winner inside the window, an unchanged winner inside the window, a vanished winner inside the window and a winner outside the window. The done latency shows whether the automatic full sweep ran, and the published ID shows whether the merge was right. The message candidate is tried with all enables set and with single enables dropped. Group codes are tried with and without the security-disable input, and requests are also driven while busy and with the reserved kind.

// File: rtl/prio_pick_pkg.sv
`timescale 1ns/1ps
package prio_pick_pkg;

    localparam int unsigned ID_W   = 16;
    localparam int unsigned PRIO_W = 8;
    localparam int unsigned N_PRIV = 32;
    localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;

    typedef enum logic [1:0] {
        GRP_0   = 2'd0,
        GRP_1S  = 2'd1,
        GRP_1NS = 2'd2
    } grp_e;

    typedef enum logic [1:0] {
        REQ_FULL   = 2'd0,
        REQ_SHARED = 2'd1,
        REQ_LOCAL  = 2'd2,
        REQ_NONE   = 2'd3
    } req_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_SH,
        ST_PV,
        ST_MSG,
        ST_CHECK,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
        grp_e              grp;
    } entry_t;

    typedef struct packed {
        logic   hit;
        entry_t ent;
    } cand_t;

    localparam entry_t ENT_NONE = '{id: '1, prio: PRIO_IDLE, grp: GRP_0};

    // Candidate c takes precedence over recorded b (equal entries count too).
    function automatic logic beats(entry_t c, entry_t b);
        return (c.prio < b.prio) || ((c.prio == b.prio) && (c.id <= b.id));
    endfunction

    function automatic grp_e grp_of(logic g, logic m, logic sec_dis);
        if (g)
            return GRP_1NS;
        else if (m && !sec_dis)
            return GRP_1S;
        else
            return GRP_0;
    endfunction

endpackage

// File: rtl/pp_cand.sv
`timescale 1ns/1ps
module pp_cand
    import prio_pick_pkg::*;
#(
    parameter int unsigned NUM_SHARED = 32,
    localparam int unsigned NUM_IDS   = N_PRIV + NUM_SHARED,
    localparam int unsigned IXW       = $clog2(NUM_IDS),
    localparam int unsigned CW        = IXW + 1
) (
    input  logic [CW-1:0]             idx_i,
    input  logic                      msg_phase_i,
    input  logic [NUM_IDS-1:0]        elig_i,
    input  logic [NUM_SHARED-1:0]     route_ok_i,
    input  logic [NUM_IDS*PRIO_W-1:0] prio_i,
    input  logic [NUM_IDS-1:0]        grp_i,
    input  logic [NUM_IDS-1:0]        gmod_i,
    input  logic                      sec_dis_i,
    input  logic                      msg_lcl_en_i,
    input  logic                      msg_glb_en_i,
    input  logic                      g1ns_en_i,
    input  logic [ID_W-1:0]           msg_id_i,
    input  logic [PRIO_W-1:0]         msg_prio_i,
    input  logic [1:0]                msg_grp_i,
    output cand_t                     cand_o
);

    logic [PRIO_W-1:0] prio_arr [NUM_IDS];
    grp_e              grp_arr  [NUM_IDS];
    logic [NUM_IDS-1:0] routed;

    // Private IDs always route to this processor; shared IDs use their bit.
    assign routed = {route_ok_i, {N_PRIV{1'b1}}};

    for (genvar g = 0; g < NUM_IDS; g++) begin : g_unpack
        assign prio_arr[g] = prio_i[g*PRIO_W +: PRIO_W];
        assign grp_arr[g]  = grp_of(grp_i[g], gmod_i[g], sec_dis_i);
    end

    logic [IXW-1:0] ix;
    logic           in_rng;
    logic           msg_ok;

    assign ix     = idx_i[IXW-1:0];
    assign in_rng = idx_i < CW'(NUM_IDS);
    assign msg_ok = msg_lcl_en_i && msg_glb_en_i && g1ns_en_i &&
                    (msg_prio_i != PRIO_IDLE);

    always_comb begin
        if (msg_phase_i) begin
            cand_o.hit      = msg_ok;
            cand_o.ent.id   = msg_id_i;
            cand_o.ent.prio = msg_prio_i;
            cand_o.ent.grp  = grp_e'(msg_grp_i);
        end else begin
            cand_o.hit      = in_rng && elig_i[ix] && routed[ix] &&
                              (prio_arr[ix] != PRIO_IDLE);
            cand_o.ent.id   = ID_W'(idx_i);
            cand_o.ent.prio = prio_arr[ix];
            cand_o.ent.grp  = grp_arr[ix];
        end
    end

endmodule

// File: rtl/pp_ctrl.sv
`timescale 1ns/1ps
module pp_ctrl
    import prio_pick_pkg::*;
#(
    parameter int unsigned NUM_SHARED = 32,
    parameter int unsigned MSG_BASE   = 8192,
    localparam int unsigned NUM_IDS   = N_PRIV + NUM_SHARED,
    localparam int unsigned CW        = $clog2(NUM_IDS) + 1,
    localparam int unsigned XW        = ID_W + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_i,
    input  logic [1:0]      req_kind_i,
    input  logic [ID_W-1:0] upd_first_i,
    input  logic [ID_W-1:0] upd_count_i,
    input  entry_t          best_i,
    input  logic            seen_i,
    output logic            start_o,
    output logic            clear_o,
    output logic            scan_o,
    output logic            msg_phase_o,
    output logic            pub_o,
    output logic            busy_o,
    output logic [CW-1:0]   idx_o
);

    state_e        st_q;
    req_e          kind_q;
    logic          full_q;
    logic [CW-1:0] idx_q;
    logic [XW-1:0] lo_q, end_q;

    // Window of a shared-range request, clipped to the shared region.
    logic [XW-1:0] lo_w, sum_w, end_w;
    always_comb begin
        lo_w  = (upd_first_i < ID_W'(N_PRIV)) ? XW'(N_PRIV) : {1'b0, upd_first_i};
        sum_w = {1'b0, upd_first_i} + {1'b0, upd_count_i};
        end_w = (sum_w > XW'(NUM_IDS)) ? XW'(NUM_IDS) : sum_w;
    end

    // Was the old winner inside the region the last sweep covered?
    logic in_zone, fallback;
    always_comb begin
        if (kind_q == REQ_SHARED)
            in_zone = ({1'b0, best_i.id} >= lo_q) && ({1'b0, best_i.id} < end_q);
        else
            in_zone = (best_i.id < ID_W'(N_PRIV)) || (best_i.id >= ID_W'(MSG_BASE));
        fallback = !seen_i && (best_i.prio != PRIO_IDLE) && in_zone;
    end

    assign start_o     = (st_q == ST_IDLE) && req_i && (req_e'(req_kind_i) != REQ_NONE);
    assign clear_o     = (st_q == ST_CLEAR);
    assign scan_o      = (st_q == ST_SH) || (st_q == ST_PV);
    assign msg_phase_o = (st_q == ST_MSG);
    assign pub_o       = (st_q == ST_DONE);
    assign busy_o      = (st_q != ST_IDLE);
    assign idx_o       = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            kind_q <= REQ_FULL;
            full_q <= 1'b0;
            idx_q  <= '0;
            lo_q   <= '0;
            end_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_o) begin
                        kind_q <= req_e'(req_kind_i);
                        unique case (req_e'(req_kind_i))
                            REQ_SHARED: begin
                                full_q <= 1'b0;
                                lo_q   <= lo_w;
                                end_q  <= end_w;
                                idx_q  <= lo_w[CW-1:0];
                                st_q   <= (lo_w >= end_w) ? ST_CHECK : ST_SH;
                            end
                            REQ_LOCAL: begin
                                full_q <= 1'b0;
                                idx_q  <= '0;
                                st_q   <= ST_PV;
                            end
                            default: begin
                                full_q <= 1'b1;
                                st_q   <= ST_CLEAR;
                            end
                        endcase
                    end
                end
                ST_CLEAR: begin
                    idx_q <= CW'(N_PRIV);
                    end_q <= XW'(NUM_IDS);
                    st_q  <= ST_SH;
                end
                ST_SH: begin
                    if (XW'(idx_q) == end_q - XW'(1)) begin
                        idx_q <= '0;
                        st_q  <= full_q ? ST_PV : ST_CHECK;
                    end else begin
                        idx_q <= idx_q + CW'(1);
                    end
                end
                ST_PV: begin
                    if (idx_q == CW'(N_PRIV - 1))
                        st_q <= ST_MSG;
                    else
                        idx_q <= idx_q + CW'(1);
                end
                ST_MSG: st_q <= full_q ? ST_DONE : ST_CHECK;
                ST_CHECK: begin
                    if (fallback) begin
                        full_q <= 1'b1;
                        st_q   <= ST_CLEAR;
                    end else begin
                        st_q   <= ST_DONE;
                    end
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pp_best.sv
`timescale 1ns/1ps
module pp_best
    import prio_pick_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clear_i,
    input  logic   start_i,
    input  logic   eval_i,
    input  logic   pub_i,
    input  cand_t  cand_i,
    output entry_t best_o,
    output logic   seen_o,
    output entry_t out_o,
    output logic   done_o
);

    entry_t best_q, out_q;
    logic   seen_q, done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            best_q <= ENT_NONE;
            out_q  <= ENT_NONE;
            seen_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= pub_i;
            if (pub_i)
                out_q <= best_q;
            if (clear_i) begin
                best_q <= ENT_NONE;
                seen_q <= 1'b0;
            end else if (start_i) begin
                seen_q <= 1'b0;
            end else if (eval_i && cand_i.hit && beats(cand_i.ent, best_q)) begin
                best_q <= cand_i.ent;
                seen_q <= 1'b1;
            end
        end
    end

    assign best_o = best_q;
    assign seen_o = seen_q;
    assign out_o  = out_q;
    assign done_o = done_q;

endmodule

// File: rtl/prio_pick.sv
`timescale 1ns/1ps
module prio_pick
    import prio_pick_pkg::*;
#(
    parameter int unsigned NUM_SHARED = 32,
    parameter int unsigned MSG_BASE   = 8192,
    localparam int unsigned NUM_IDS   = N_PRIV + NUM_SHARED,
    localparam int unsigned CW        = $clog2(NUM_IDS) + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_i,
    input  logic [1:0]                req_kind_i,
    input  logic [ID_W-1:0]           upd_first_i,
    input  logic [ID_W-1:0]           upd_count_i,
    input  logic [NUM_IDS-1:0]        elig_i,
    input  logic [NUM_SHARED-1:0]     route_ok_i,
    input  logic [NUM_IDS*PRIO_W-1:0] prio_i,
    input  logic [NUM_IDS-1:0]        grp_i,
    input  logic [NUM_IDS-1:0]        gmod_i,
    input  logic                      sec_dis_i,
    input  logic                      msg_lcl_en_i,
    input  logic                      msg_glb_en_i,
    input  logic                      g1ns_en_i,
    input  logic [ID_W-1:0]           msg_id_i,
    input  logic [PRIO_W-1:0]         msg_prio_i,
    input  logic [1:0]                msg_grp_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      valid_o,
    output logic [ID_W-1:0]           best_id_o,
    output logic [PRIO_W-1:0]         best_prio_o,
    output logic [1:0]                best_grp_o
);

    logic          start, clear, scan, msg_phase, pub, seen;
    logic [CW-1:0] idx;
    cand_t         cand;
    entry_t        best, out_ent;

    pp_ctrl #(.NUM_SHARED(NUM_SHARED), .MSG_BASE(MSG_BASE)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req_i),
        .req_kind_i  (req_kind_i),
        .upd_first_i (upd_first_i),
        .upd_count_i (upd_count_i),
        .best_i      (best),
        .seen_i      (seen),
        .start_o     (start),
        .clear_o     (clear),
        .scan_o      (scan),
        .msg_phase_o (msg_phase),
        .pub_o       (pub),
        .busy_o      (busy_o),
        .idx_o       (idx)
    );

    pp_cand #(.NUM_SHARED(NUM_SHARED)) u_cand (
        .idx_i        (idx),
        .msg_phase_i  (msg_phase),
        .elig_i       (elig_i),
        .route_ok_i   (route_ok_i),
        .prio_i       (prio_i),
        .grp_i        (grp_i),
        .gmod_i       (gmod_i),
        .sec_dis_i    (sec_dis_i),
        .msg_lcl_en_i (msg_lcl_en_i),
        .msg_glb_en_i (msg_glb_en_i),
        .g1ns_en_i    (g1ns_en_i),
        .msg_id_i     (msg_id_i),
        .msg_prio_i   (msg_prio_i),
        .msg_grp_i    (msg_grp_i),
        .cand_o       (cand)
    );

    pp_best u_best (
        .clk     (clk),
        .rst     (rst),
        .clear_i (clear),
        .start_i (start),
        .eval_i  (scan || msg_phase),
        .pub_i   (pub),
        .cand_i  (cand),
        .best_o  (best),
        .seen_o  (seen),
        .out_o   (out_ent),
        .done_o  (done_o)
    );

    assign valid_o     = (out_ent.prio != PRIO_IDLE);
    assign best_id_o   = out_ent.id;
    assign best_prio_o = out_ent.prio;
    assign best_grp_o  = out_ent.grp;

endmodule

// File: rtl/prio_pick_chk.sv
`timescale 1ns/1ps
module prio_pick_chk
    import prio_pick_pkg::*;
#(
    parameter int unsigned MSG_BASE = 8192,
    parameter int unsigned NUM_IDS  = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              valid_o,
    input logic [ID_W-1:0]   best_id_o,
    input logic [PRIO_W-1:0] best_prio_o,
    input logic [1:0]        best_grp_o
);

    // R9
    done_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable({valid_o, best_id_o, best_prio_o, best_grp_o}));

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(busy_o));

    // R10
    start_by_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(req_i));

    // R1
    valid_id_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && valid_o) |->
            ((best_id_o < ID_W'(NUM_IDS)) || (best_id_o >= ID_W'(MSG_BASE))));

endmodule

bind prio_pick prio_pick_chk #(.MSG_BASE(MSG_BASE), .NUM_IDS(NUM_IDS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .valid_o     (valid_o),
    .best_id_o   (best_id_o),
    .best_prio_o (best_prio_o),
    .best_grp_o  (best_grp_o)
);

// File: tb/prio_pick_bench.sv
`timescale 1ns/1ps
module prio_pick_bench;

    localparam int NS   = 32;
    localparam int NIDS = NS + 32;
    localparam int MB   = 8192;
    localparam int LAT_FULL = NS + 35;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic [1:0]        kind = 2'd0;
    logic [15:0]       ufirst = '0, ucnt = '0;
    logic [NIDS-1:0]   elig, grp, gmod;
    logic [NS-1:0]     route;
    logic [NIDS*8-1:0] prio;
    logic              sec_dis, m_lcl, m_glb, g1ns;
    logic [15:0]       m_id;
    logic [7:0]        m_prio;
    logic [1:0]        m_grp;
    logic              busy, done, valid;
    logic [15:0]       bid;
    logic [7:0]        bprio;
    logic [1:0]        bgrp;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    prio_pick #(.NUM_SHARED(NS), .MSG_BASE(MB)) u_prio_pick (
        .clk(clk), .rst(rst), .req_i(req), .req_kind_i(kind),
        .upd_first_i(ufirst), .upd_count_i(ucnt),
        .elig_i(elig), .route_ok_i(route), .prio_i(prio),
        .grp_i(grp), .gmod_i(gmod), .sec_dis_i(sec_dis),
        .msg_lcl_en_i(m_lcl), .msg_glb_en_i(m_glb), .g1ns_en_i(g1ns),
        .msg_id_i(m_id), .msg_prio_i(m_prio), .msg_grp_i(m_grp),
        .busy_o(busy), .done_o(done), .valid_o(valid),
        .best_id_o(bid), .best_prio_o(bprio), .best_grp_o(bgrp)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_cfg();
        elig = '0; grp = '0; gmod = '0; route = '1; prio = '1;
        sec_dis = 0; m_lcl = 0; m_glb = 0; g1ns = 0;
        m_id = 16'(MB); m_prio = 8'hFF; m_grp = 2'd0;
    endtask

    task automatic set_irq(input int id, input int p);
        elig[id] = 1'b1;
        prio[id*8 +: 8] = 8'(p);
    endtask

    // Issue a request, return the edges from the accepting edge to done.
    task automatic run(input int k, input int first, input int cnt, output int lat);
        @(negedge clk);
        req = 1'b1; kind = 2'(k); ufirst = 16'(first); ucnt = 16'(cnt);
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        lat = 0;
        while (!done && lat < 1000) begin
            @(posedge clk); lat++;
            @(negedge clk);
        end
    endtask

    task automatic expect_win(input string tag, input int id, input int p, input int g);
        chk({tag, " valid"}, int'(valid), 1);
        chk({tag, " id"}, int'(bid), id);
        chk({tag, " prio"}, int'(bprio), p);
        chk({tag, " grp"}, int'(bgrp), g);
    endtask

    task automatic t_reset();
        chk("R1 reset valid", int'(valid), 0);
        chk("R1 reset prio", int'(bprio), 255);
        chk("R9 reset busy", int'(busy), 0);
        chk("R9 reset done", int'(done), 0);
    endtask

    task automatic t_full();
        int lat;
        clear_cfg();
        set_irq(40, 8'h20); set_irq(50, 8'h10); set_irq(3, 8'h30);
        grp[50] = 1'b1;
        run(0, 0, 0, lat);
        expect_win("R1 full", 50, 8'h10, 2);
        chk("R11 full latency", lat, LAT_FULL);
        @(negedge clk);
        chk("R9 done width", int'(done), 0);
    endtask

    task automatic t_tie();
        int lat;
        clear_cfg();
        set_irq(45, 8'h10); set_irq(60, 8'h10); set_irq(7, 8'h10); set_irq(3, 8'h40);
        run(0, 0, 0, lat);
        expect_win("R2 tie private", 7, 8'h10, 0);
        elig[7] = 1'b0;
        run(0, 0, 0, lat);
        expect_win("R2 tie shared", 45, 8'h10, 0);
    endtask

    task automatic t_route();
        int lat;
        clear_cfg();
        set_irq(33, 8'h01); set_irq(40, 8'h20);
        route[1] = 1'b0;
        run(0, 0, 0, lat);
        expect_win("R3 unrouted", 40, 8'h20, 0);
        route[1] = 1'b1;
        run(0, 0, 0, lat);
        expect_win("R3 routed", 33, 8'h01, 0);
    endtask

    task automatic t_none();
        int lat;
        clear_cfg();
        set_irq(36, 8'hFF);
        run(0, 0, 0, lat);
        chk("R1 idle prio valid", int'(valid), 0);
        chk("R1 idle prio value", int'(bprio), 255);
    endtask

    task automatic t_incr();
        int lat;
        clear_cfg();
        set_irq(7, 8'h10);
        run(0, 0, 0, lat);
        expect_win("R4 base", 7, 8'h10, 0);
        set_irq(55, 8'h05);
        run(1, 48, 16, lat);
        expect_win("R4 range new", 55, 8'h05, 0);
        chk("R4 range latency", lat, 18);
        run(1, 48, 16, lat);
        expect_win("R5 same winner", 55, 8'h05, 0);
        chk("R5 no rescan latency", lat, 18);
        elig[55] = 1'b0;
        run(1, 48, 16, lat);
        expect_win("R6 fallback", 7, 8'h10, 0);
        chk("R6 fallback latency", lat, 16 + 68);
        set_irq(62, 8'h30);
        run(1, 56, 8, lat);
        expect_win("R4 outside window", 7, 8'h10, 0);
        chk("R4 outside latency", lat, 10);
    endtask

    task automatic t_msg();
        int lat;
        clear_cfg();
        set_irq(7, 8'h10);
        run(0, 0, 0, lat);
        m_lcl = 1; m_glb = 1; g1ns = 1; m_prio = 8'h02; m_grp = 2'd2;
        run(2, 0, 0, lat);
        expect_win("R8 msg taken", MB, 8'h02, 2);
        chk("R11 local latency", lat, 35);
        m_glb = 0;
        run(2, 0, 0, lat);
        expect_win("R6 msg disabled fallback", 7, 8'h10, 0);
        chk("R6 local fallback latency", lat, 34 + LAT_FULL);
        m_glb = 1; g1ns = 0;
        run(2, 0, 0, lat);
        expect_win("R8 g1ns off", 7, 8'h10, 0);
        g1ns = 1;
        run(1, 32, 32, lat);
        expect_win("R8 not in shared sweep", 7, 8'h10, 0);
    endtask

    task automatic t_group();
        int lat;
        clear_cfg();
        set_irq(7, 8'h10); gmod[7] = 1'b1;
        run(0, 0, 0, lat);
        expect_win("R7 modifier", 7, 8'h10, 1);
        sec_dis = 1'b1;
        run(0, 0, 0, lat);
        expect_win("R7 sec disabled", 7, 8'h10, 0);
    endtask

    task automatic t_busy();
        int lat;
        bit extra;
        clear_cfg();
        set_irq(40, 8'h20);
        @(negedge clk);
        req = 1'b1; kind = 2'd0;
        @(posedge clk);
        @(negedge clk);
        kind = 2'd1; ufirst = 16'd32; ucnt = 16'd1;
        lat = 0;
        @(posedge clk); lat++;
        @(negedge clk);
        req = 1'b0;
        while (!done && lat < 1000) begin
            @(posedge clk); lat++;
            @(negedge clk);
        end
        chk("R10 busy request ignored latency", lat, LAT_FULL);
        expect_win("R10 busy result", 40, 8'h20, 0);
        extra = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (done || busy) extra = 1;
        end
        chk("R10 no second sweep", int'(extra), 0);
        req = 1'b1; kind = 2'd3;
        @(negedge clk);
        req = 1'b0;
        extra = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (busy || done) extra = 1;
        end
        chk("R10 reserved kind ignored", int'(extra), 0);
    endtask

    initial begin
        clear_cfg();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full();
        t_tie();
        t_route();
        t_none();
        t_incr();
        t_msg();
        t_group();
        t_busy();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule